// File: doc/BRIEF.md
# Cycle-Stealing DMA Sequencer

This block sequences the machine cycles of a small byte-wide processor and inserts direct-memory-access cycles into that stream without disturbing the program. Every clock is one machine cycle. The block keeps the code of the cycle in progress and shows it on a 2-bit state code. When the next cycle is a program cycle, it takes that cycle from the program stream: an input says whether the next program cycle is a fetch or an execute. A pulse tells the stream that it has moved on by one cycle. When a device asks for a transfer, the block steals cycles after an execute cycle and holds the program back until the transfers are done.

During a stolen cycle a dedicated 16-bit address register points into a synchronous byte memory. An inbound transfer writes the device byte to that address. An outbound transfer reads the addressed byte, which the memory returns one clock later, and hands it to the device. The address register advances by one after each stolen cycle, so a held request fills or drains consecutive locations. A host may preload the register between transfers. An interrupt cycle can also be inserted, but only when no transfer is waiting.

Top module: `dma_steal_seq`

## Requirements
- R1: After reset the state code is 00 (fetch), the address register is 0x0000, and both the memory write enable and the outbound-data valid flag are low.
- R2: With no transfer or interrupt request, the next cycle takes its code from the program stream: 01 (execute) when prog_exec_i is high and 00 (fetch) when it is low. prog_take_o is high in every cycle that takes such a program cycle.
- R3: A transfer request present during an execute cycle (01) makes the next cycle a stolen cycle with code 10, and prog_take_o is low for that choice.
- R4: A transfer request present during a fetch cycle (00) does not start a stolen cycle next. The next cycle is a program cycle.
- R5: While a request stays asserted during a stolen cycle, the next cycle is stolen too.
- R6: In an inbound stolen cycle, mem_en_o and mem_we_o are high, mem_addr_o equals the address register, and mem_wdata_o equals dev_in_i.
- R7: In an outbound stolen cycle, mem_en_o is high and mem_we_o is low. In the following cycle dev_out_vld_o is high and dev_out_o carries the byte the memory returned.
- R8: The address register increases by one at the end of every stolen cycle and wraps from 0xFFFF to 0x0000.
- R9: When inbound and outbound requests are both present, the inbound transfer is served first.
- R10: An interrupt request present during an execute or stolen cycle gives a cycle with code 11 next, but only when no transfer request is present. A transfer request is always served before an interrupt.
- R11: A host load of the address register takes effect in a cycle that is not stolen. A load asserted during a stolen cycle is ignored, and the register only advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_exec_i | input | 1 | Next program cycle is execute (1) or fetch (0) |
| prog_take_o | output | 1 | The next cycle is taken from the program stream |
| dma_in_req_i | input | 1 | Inbound transfer request (device to memory) |
| dma_out_req_i | input | 1 | Outbound transfer request (memory to device) |
| int_req_i | input | 1 | Interrupt request |
| sc_o | output | 2 | Code of the cycle in progress |
| r0_ld_i | input | 1 | Host load strobe for the address register |
| r0_ld_val_i | input | 16 | Value to load into the address register |
| r0_o | output | 16 | Address register value |
| dev_in_i | input | 8 | Byte from the device for inbound transfers |
| dev_out_o | output | 8 | Byte to the device from outbound transfers |
| dev_out_vld_o | output | 1 | dev_out_o holds a byte that was read for an outbound transfer |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid one clock after the read |

## Verification
The hardest situation to reach is a host load that arrives during a run of stolen cycles, because it competes with the increment in the same cycle. The stimulus holds an inbound request across two stolen cycles and raises the load strobe in the first, so the register must show the increment and not the loaded value. A second hard case is an interrupt and a transfer requested together. The bench raises both during an execute cycle, sees the stolen cycle first, then drops only the transfer request and expects the interrupt cycle next.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    SC_FETCH = 2'b00,
    SC_EXEC  = 2'b01,
    SC_DMA   = 2'b10,
    SC_INT   = 2'b11
  } sc_t;

  typedef enum logic {
    DIR_IN  = 1'b0,
    DIR_OUT = 1'b1
  } dir_t;
endpackage

// File: rtl/dma_cycle_sel.sv
module dma_cycle_sel
  import dma_seq_pkg::*;
(
  input  sc_t  cur_sc_i,
  input  logic in_req_i,
  input  logic out_req_i,
  input  logic int_req_i,
  input  logic prog_exec_i,
  output sc_t  nxt_sc_o,
  output dir_t nxt_dir_o,
  output logic prog_take_o
);
  logic steal_window;
  logic any_dma;

  assign steal_window = (cur_sc_i == SC_EXEC) || (cur_sc_i == SC_DMA);
  assign any_dma      = in_req_i || out_req_i;

  always_comb begin
    nxt_sc_o    = prog_exec_i ? SC_EXEC : SC_FETCH;
    nxt_dir_o   = DIR_IN;
    prog_take_o = 1'b1;
    if (steal_window && any_dma) begin
      nxt_sc_o    = SC_DMA;
      nxt_dir_o   = in_req_i ? DIR_IN : DIR_OUT;
      prog_take_o = 1'b0;
    end else if (steal_window && int_req_i) begin
      nxt_sc_o    = SC_INT;
      prog_take_o = 1'b0;
    end
  end
endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_val_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  assign addr_en = step_i || ld_i;

  always_comb begin
    addr_d = addr_q;
    if (step_i)    addr_d = addr_q + AW'(1);
    else if (ld_i) addr_d = ld_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  // R8
  step_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (addr_o == $past(addr_o) + AW'(1)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !ld_i) |=> $stable(addr_o));
endmodule

// File: rtl/dma_xfer_path.sv
module dma_xfer_path
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_act_i,
  input  dir_t          dir_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] dev_in_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [DW-1:0] dev_out_o,
  output logic          dev_out_vld_o
);
  logic rd_pend_q, rd_pend_d;

  assign mem_en_o    = dma_act_i;
  assign mem_we_o    = dma_act_i && (dir_i == DIR_IN);
  assign mem_addr_o  = addr_i;
  assign mem_wdata_o = dev_in_i;

  assign rd_pend_d = dma_act_i && (dir_i == DIR_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend_q <= 1'b0;
    else        rd_pend_q <= rd_pend_d;
  end

  assign dev_out_vld_o = rd_pend_q;
  assign dev_out_o     = mem_rdata_i;

  // R7
  out_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && !mem_we_o) |=> dev_out_vld_o);

  // R6
  write_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_en_o);
endmodule

// File: rtl/dma_steal_seq.sv
module dma_steal_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_exec_i,
  output logic          prog_take_o,
  input  logic          dma_in_req_i,
  input  logic          dma_out_req_i,
  input  logic          int_req_i,
  output logic [1:0]    sc_o,
  input  logic          r0_ld_i,
  input  logic [AW-1:0] r0_ld_val_i,
  output logic [AW-1:0] r0_o,
  input  logic [DW-1:0] dev_in_i,
  output logic [DW-1:0] dev_out_o,
  output logic          dev_out_vld_o,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sc_t  cur_sc_q, nxt_sc;
  dir_t cur_dir_q, nxt_dir;
  logic dma_act;

  dma_cycle_sel u_sel (
    .cur_sc_i   (cur_sc_q),
    .in_req_i   (dma_in_req_i),
    .out_req_i  (dma_out_req_i),
    .int_req_i  (int_req_i),
    .prog_exec_i(prog_exec_i),
    .nxt_sc_o   (nxt_sc),
    .nxt_dir_o  (nxt_dir),
    .prog_take_o(prog_take_o)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cur_sc_q  <= SC_FETCH;
      cur_dir_q <= DIR_IN;
    end else begin
      cur_sc_q  <= nxt_sc;
      cur_dir_q <= nxt_dir;
    end
  end

  assign dma_act = (cur_sc_q == SC_DMA);
  assign sc_o    = cur_sc_q;

  dma_addr_reg #(.AW(AW)) u_r0 (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .step_i  (dma_act),
    .ld_i    (r0_ld_i),
    .ld_val_i(r0_ld_val_i),
    .addr_o  (r0_o)
  );

  dma_xfer_path #(.AW(AW), .DW(DW)) u_xfer (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .dma_act_i    (dma_act),
    .dir_i        (cur_dir_q),
    .addr_i       (r0_o),
    .dev_in_i     (dev_in_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_en_o     (mem_en_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .dev_out_o    (dev_out_o),
    .dev_out_vld_o(dev_out_vld_o)
  );

  // R3 R9
  exec_in_steal_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sc_o == 2'b01 && dma_in_req_i) |=> (sc_o == 2'b10 && mem_we_o));

  // R4
  fetch_no_steal_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sc_o == 2'b00) |=> (sc_o != 2'b10));

  // R2
  take_is_prog_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    prog_take_o |=> (sc_o[1] == 1'b0));

  // R10
  int_defer_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sc_o == 2'b11) |-> !$past(dma_in_req_i || dma_out_req_i));
endmodule

// File: tb/dma_steal_seq_bench.sv
module dma_steal_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        prog_exec, prog_take, in_req, out_req, int_req;
  logic [1:0]  sc;
  logic        ld;
  logic [15:0] ld_val, r0, mem_addr;
  logic [7:0]  dev_in, dev_out, mem_wdata, mem_rdata;
  logic        dev_out_vld, mem_en, mem_we;
  int          checks = 0;
  int          failures = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  dma_steal_seq u_dma_steal_seq (
    .clk(clk), .rst_n(rst_n), .prog_exec_i(prog_exec), .prog_take_o(prog_take),
    .dma_in_req_i(in_req), .dma_out_req_i(out_req), .int_req_i(int_req),
    .sc_o(sc), .r0_ld_i(ld), .r0_ld_val_i(ld_val), .r0_o(r0),
    .dev_in_i(dev_in), .dev_out_o(dev_out), .dev_out_vld_o(dev_out_vld),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk)
    if (mem_en && !mem_we) mem_rdata <= mem_addr[7:0] ^ 8'h5A;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    chk("R1 sc", sc, 2'b00);
    chk("R1 r0", r0, 16'h0000);
    chk("R1 we", mem_we, 1'b0);
    chk("R1 vld", dev_out_vld, 1'b0);
  endtask

  task automatic t_prog();
    prog_exec = 0; #1;
    chk("R2 take", prog_take, 1'b1);
    tick(); chk("R2 fetch", sc, 2'b00);
    prog_exec = 1; tick(); chk("R2 exec", sc, 2'b01);
    prog_exec = 0; tick(); chk("R2 fetch again", sc, 2'b00);
  endtask

  task automatic t_dma_in();
    ld = 1; ld_val = 16'h1234; tick(); ld = 0;
    chk("R11 load", r0, 16'h1234);
    prog_exec = 1; in_req = 1; #1;
    chk("R4 take in fetch", prog_take, 1'b1);
    tick(); chk("R4 no steal after fetch", sc, 2'b01);
    #1; chk("R3 take low", prog_take, 1'b0);
    dev_in = 8'h3C;
    tick();
    chk("R3 steal", sc, 2'b10);
    chk("R6 we", mem_we, 1'b1);
    chk("R6 en", mem_en, 1'b1);
    chk("R6 addr", mem_addr, 16'h1234);
    chk("R6 wdata", mem_wdata, 8'h3C);
    tick();
    chk("R5 still steal", sc, 2'b10);
    chk("R8 incr", r0, 16'h1235);
    in_req = 0; prog_exec = 0; tick();
    chk("R2 back to program", sc, 2'b00);
    chk("R8 incr2", r0, 16'h1236);
  endtask

  task automatic t_dma_out();
    ld = 1; ld_val = 16'h0040; tick(); ld = 0;
    prog_exec = 1; tick();
    out_req = 1; tick();
    chk("R7 steal", sc, 2'b10);
    chk("R7 we low", mem_we, 1'b0);
    chk("R7 en", mem_en, 1'b1);
    chk("R7 addr", mem_addr, 16'h0040);
    out_req = 0; prog_exec = 0; tick();
    chk("R7 vld", dev_out_vld, 1'b1);
    chk("R7 data", dev_out, 8'h1A);
    chk("R8 out incr", r0, 16'h0041);
    tick(); chk("R7 vld drop", dev_out_vld, 1'b0);
  endtask

  task automatic t_prio();
    prog_exec = 1; tick();
    in_req = 1; out_req = 1; tick();
    chk("R9 in first", mem_we, 1'b1);
    in_req = 0; tick();
    chk("R9 out next sc", sc, 2'b10);
    chk("R9 out next we", mem_we, 1'b0);
    out_req = 0; prog_exec = 0; tick();
    chk("R9 done", sc, 2'b00);
  endtask

  task automatic t_wrap();
    ld = 1; ld_val = 16'hFFFF; tick(); ld = 0;
    prog_exec = 1; tick();
    in_req = 1; tick();
    chk("R8 wrap addr", mem_addr, 16'hFFFF);
    in_req = 0; prog_exec = 0; tick();
    chk("R8 wrap", r0, 16'h0000);
  endtask

  task automatic t_int();
    prog_exec = 1; tick();
    int_req = 1; #1;
    chk("R10 take low", prog_take, 1'b0);
    tick(); chk("R10 int cycle", sc, 2'b11);
    int_req = 0; prog_exec = 0; tick();
    chk("R10 after int", sc, 2'b00);
    prog_exec = 1; tick();
    int_req = 1; in_req = 1; tick();
    chk("R10 dma before int", sc, 2'b10);
    in_req = 0; tick();
    chk("R10 int after dma", sc, 2'b11);
    int_req = 0; prog_exec = 0; tick();
    chk("R10 program resumes", sc, 2'b00);
  endtask

  task automatic t_ld_ignore();
    prog_exec = 1; tick();
    in_req = 1; tick();
    chk("R11 pre", r0, 16'h0001);
    ld = 1; ld_val = 16'h5555; tick(); ld = 0;
    chk("R11 load ignored", r0, 16'h0002);
    in_req = 0; prog_exec = 0; tick();
    chk("R11 after", r0, 16'h0003);
  endtask

  initial begin
    rst_n = 0; prog_exec = 0; in_req = 0; out_req = 0; int_req = 0;
    ld = 0; ld_val = 0; dev_in = 0; mem_rdata = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    t_reset();
    t_prog();
    t_dma_in();
    t_dma_out();
    t_prio();
    t_wrap();
    t_int();
    t_ld_ignore();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule